// File: doc/BRIEF.md
# Page ECC Encoder and Checker

This block protects a 2048-byte flash page with a spare area of 64 bytes. The page is split into eight chunks of 256 bytes each. Each chunk gets a 24-bit single-error-correcting parity code. When a page is written, the host streams the page bytes through the block. The block then streams out the complete spare area, with the eight codes packed at its tail and every other byte set to 0xFF.

When a page is read, the host streams the stored spare area first and then the page bytes. The block holds each chunk in a local buffer and recomputes its code. It compares the new code with the stored one and reports one of four outcomes for that chunk. If a single data bit has flipped, the block flips it back. It then releases the chunk downstream, tagged with its chunk number and byte position. An uncorrectable chunk marks the whole page as failed.

Top module: `pg_ecc_engine`

## Requirements
- R1: In encode mode the block produces one 24-bit code per chunk. Code bit 2j is the XOR of the parities of all bytes whose position within the chunk has bit j clear, and bit 2j+1 covers the positions with bit j set (j = 0..7). Bits 16+2k and 17+2k are the same pair over the bit positions within the byte, for bit k of that position clear and set (k = 0..2). Bits 23:22 are always 1.
- R2: In the spare area, bytes 0 to 39 do not carry a code. They are emitted as 0xFF in encode mode and ignored in decode mode.
- R3: The code v of chunk c occupies spare bytes 40+3c, 41+3c and 42+3c, holding v[15:8], v[7:0] and v[23:16] in that order. Decode mode reassembles stored codes with the same mapping.
- R4: In decode mode the input stream is the 64 spare bytes followed by the 2048 page bytes. Each chunk is followed by one check cycle and then 256 output cycles in position order, labelled with the chunk number and the byte position.
- R5: If the syndrome (stored XOR recomputed) is zero, the result is 0 (clean) and the chunk is released unchanged.
- R6: If every one of the 11 even/odd pairs of the syndrome differs and bits 23:22 of the syndrome are clear, the result is 1 (data bit fixed). The byte named by the odd line bits has the bit named by the odd column bits inverted before release.
- R7: Otherwise, if exactly one syndrome bit is set, the result is 2 (code bit error) and the data is released unchanged.
- R8: Any other syndrome gives result 3 (uncorrectable). The chunk is released unmodified, and page_fail rises the cycle after the check and stays high until the next page starts.
- R9: page_done pulses for one cycle right after the last spare byte (encode) or the last released byte (decode). page_start is acted on only while idle and is ignored during a page.
- R10: After reset, and whenever the block is idle, checking or emitting, in_ready is low. It is high only while spare or page bytes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | Begins a page when idle |
| start_decode | input | 1 | Mode sampled with page_start: 1 decode, 0 encode |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte (spare or page data) |
| in_ready | output | 1 | Block accepts a byte this cycle |
| dout_valid | output | 1 | Released page byte valid (decode) |
| dout_data | output | 8 | Released, possibly corrected, byte |
| dout_chunk | output | 3 | Chunk number of the released byte |
| dout_pos | output | 8 | Byte position within the chunk |
| chk_valid | output | 1 | Chunk check result valid |
| chk_result | output | 2 | 0 clean, 1 data fixed, 2 code bit error, 3 uncorrectable |
| chk_chunk | output | 3 | Chunk the result applies to |
| spare_valid | output | 1 | Spare byte valid (encode) |
| spare_data | output | 8 | Spare byte value |
| spare_idx | output | 6 | Spare byte index |
| page_done | output | 1 | One-cycle end-of-page pulse |
| page_fail | output | 1 | Page has an uncorrectable chunk |

## Verification
Encode pages with different data seeds check the code layout and the 0xFF padding against codes computed from the parity definition. Decode pages are tried clean, with one flipped data bit at the first and last byte of the page and at a middle byte, and with one flipped code bit in the line, column and always-one fields. Another page has two flipped data bits, which must be reported as uncorrectable and not miscorrected. A clean page after the failed one shows that page_fail is cleared. A page_start pulse issued during an encode page confirms it is ignored.

// File: rtl/pg_ecc_pkg.sv
package pg_ecc_pkg;

    localparam int CODE_W = 24;

    typedef enum logic [1:0] {
        CHK_CLEAN = 2'd0,
        CHK_FIXED = 2'd1,
        CHK_CODE  = 2'd2,
        CHK_FAIL  = 2'd3
    } chk_res_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SPARE_IN  = 3'd1,
        ST_DATA      = 3'd2,
        ST_CHECK     = 3'd3,
        ST_DRAIN     = 3'd4,
        ST_SPARE_OUT = 3'd5
    } eng_st_e;

endpackage

// File: rtl/pg_ecc_acc.sv
// Running line/column parity over one chunk; code reflects bytes seen since clr.
module pg_ecc_acc import pg_ecc_pkg::*; #(
    parameter int CHUNK_BYTES = 256
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           en,
    input  logic [$clog2(CHUNK_BYTES)-1:0] idx,
    input  logic [7:0]                     data,
    output logic [CODE_W-1:0]              code
);
    localparam int IDX_W  = $clog2(CHUNK_BYTES);
    localparam int LINE_W = 2 * IDX_W;
    localparam int PAD_W  = CODE_W - LINE_W - 6;

    typedef struct packed {
        logic [7:0]        col;
        logic [LINE_W-1:0] line;
    } acc_t;

    acc_t acc_q, acc_d;
    logic bpar;
    logic [5:0] colp;

    always_comb begin
        acc_d = acc_q;
        bpar  = ^data;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            acc_d.col = acc_q.col ^ data;
            for (int j = 0; j < IDX_W; j++) begin
                if (idx[j]) acc_d.line[2*j+1] = acc_q.line[2*j+1] ^ bpar;
                else        acc_d.line[2*j]   = acc_q.line[2*j]   ^ bpar;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    always_comb begin
        colp = '0;
        for (int k = 0; k < 3; k++) begin
            for (int n = 0; n < 8; n++) begin
                if (n[k]) colp[2*k+1] = colp[2*k+1] ^ acc_q.col[n];
                else      colp[2*k]   = colp[2*k]   ^ acc_q.col[n];
            end
        end
    end

    assign code = {{PAD_W{1'b1}}, colp, acc_q.line};

endmodule

// File: rtl/pg_ecc_syn.sv
// Syndrome classification and error location.
module pg_ecc_syn import pg_ecc_pkg::*; #(
    parameter int IDX_W = 8
) (
    input  logic [CODE_W-1:0] stored,
    input  logic [CODE_W-1:0] calc,
    output chk_res_e          result,
    output logic [IDX_W-1:0]  loc_byte,
    output logic [2:0]        loc_bit
);
    localparam int LINE_W = 2 * IDX_W;
    localparam int NPAIR  = IDX_W + 3;
    localparam int USED   = 2 * NPAIR;

    logic [CODE_W-1:0] syn;
    logic              pairs_split;
    logic              pad_clear;

    always_comb begin
        syn         = stored ^ calc;
        pairs_split = 1'b1;
        for (int j = 0; j < NPAIR; j++) begin
            if (syn[2*j] == syn[2*j+1]) pairs_split = 1'b0;
        end
        pad_clear = (syn[CODE_W-1:USED] == '0);
        for (int j = 0; j < IDX_W; j++) loc_byte[j] = syn[2*j+1];
        for (int k = 0; k < 3; k++)     loc_bit[k]  = syn[LINE_W+2*k+1];
        if (syn == '0)                       result = CHK_CLEAN;
        else if (pairs_split && pad_clear)   result = CHK_FIXED;
        else if ($countones(syn) == 1)       result = CHK_CODE;
        else                                 result = CHK_FAIL;
    end

endmodule

// File: rtl/pg_ecc_buf.sv
// Chunk holding buffer with a write port, a single-bit flip port and a read port.
module pg_ecc_buf #(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [7:0]               wdata,
    input  logic                     flip,
    input  logic [$clog2(DEPTH)-1:0] faddr,
    input  logic [7:0]               fmask,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [7:0]               rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)        mem[waddr] <= wdata;
        else if (flip) mem[faddr] <= mem[faddr] ^ fmask;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pg_ecc_engine.sv
module pg_ecc_engine import pg_ecc_pkg::*; #(
    parameter int PAGE_BYTES  = 2048,
    parameter int CHUNK_BYTES = 256,
    parameter int SPARE_BYTES = 64
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       page_start,
    input  logic                                       start_decode,
    input  logic                                       in_valid,
    input  logic [7:0]                                 in_data,
    output logic                                       in_ready,
    output logic                                       dout_valid,
    output logic [7:0]                                 dout_data,
    output logic [$clog2(PAGE_BYTES/CHUNK_BYTES)-1:0]  dout_chunk,
    output logic [$clog2(CHUNK_BYTES)-1:0]             dout_pos,
    output logic                                       chk_valid,
    output logic [1:0]                                 chk_result,
    output logic [$clog2(PAGE_BYTES/CHUNK_BYTES)-1:0]  chk_chunk,
    output logic                                       spare_valid,
    output logic [7:0]                                 spare_data,
    output logic [$clog2(SPARE_BYTES)-1:0]             spare_idx,
    output logic                                       page_done,
    output logic                                       page_fail
);
    localparam int CHUNKS   = PAGE_BYTES / CHUNK_BYTES;
    localparam int IDX_W    = $clog2(CHUNK_BYTES);
    localparam int CHUNK_W  = $clog2(CHUNKS);
    localparam int SPARE_W  = $clog2(SPARE_BYTES);
    localparam int ECC_BASE = SPARE_BYTES - 3 * CHUNKS;

    localparam logic [IDX_W-1:0]   POS_LAST   = IDX_W'(CHUNK_BYTES - 1);
    localparam logic [CHUNK_W-1:0] CHUNK_LAST = CHUNK_W'(CHUNKS - 1);
    localparam logic [SPARE_W-1:0] SP_LAST    = SPARE_W'(SPARE_BYTES - 1);
    localparam logic [SPARE_W-1:0] SP_BASE    = SPARE_W'(ECC_BASE);

    typedef struct packed {
        eng_st_e                        st;
        logic                           dec;
        logic [IDX_W-1:0]               pos;
        logic [CHUNK_W-1:0]             chunk;
        logic [SPARE_W-1:0]             sp;
        logic [CHUNK_W-1:0]             slot;
        logic [1:0]                     lane;
        logic [CHUNKS-1:0][CODE_W-1:0]  code;
        logic                           fail;
        logic                           done;
    } eng_t;

    eng_t q, d;

    logic              take;
    logic              acc_clr, acc_en;
    logic              buf_we, buf_flip;
    logic [CODE_W-1:0] acc_code;
    chk_res_e          syn_res;
    logic [IDX_W-1:0]  loc_byte;
    logic [2:0]        loc_bit;
    logic [7:0]        buf_rdata;
    logic [7:0]        sp_byte;

    pg_ecc_acc #(.CHUNK_BYTES(CHUNK_BYTES)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .idx   (q.pos),
        .data  (in_data),
        .code  (acc_code)
    );

    pg_ecc_syn #(.IDX_W(IDX_W)) u_syn (
        .stored   (q.code[q.chunk]),
        .calc     (acc_code),
        .result   (syn_res),
        .loc_byte (loc_byte),
        .loc_bit  (loc_bit)
    );

    pg_ecc_buf #(.DEPTH(CHUNK_BYTES)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (q.pos),
        .wdata (in_data),
        .flip  (buf_flip),
        .faddr (loc_byte),
        .fmask (8'b1 << loc_bit),
        .raddr (q.pos),
        .rdata (buf_rdata)
    );

    assign in_ready = (q.st == ST_SPARE_IN) || (q.st == ST_DATA);
    assign take     = in_valid && in_ready;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        acc_clr  = 1'b0;
        acc_en   = 1'b0;
        buf_we   = 1'b0;
        buf_flip = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (page_start) begin
                    d.st    = start_decode ? ST_SPARE_IN : ST_DATA;
                    d.dec   = start_decode;
                    d.pos   = '0;
                    d.chunk = '0;
                    d.sp    = '0;
                    d.slot  = '0;
                    d.lane  = '0;
                    d.fail  = 1'b0;
                    acc_clr = 1'b1;
                end
            end
            ST_SPARE_IN: begin
                if (take) begin
                    if (q.sp >= SP_BASE) begin
                        unique case (q.lane)
                            2'd0:    d.code[q.slot][15:8]  = in_data;
                            2'd1:    d.code[q.slot][7:0]   = in_data;
                            default: d.code[q.slot][23:16] = in_data;
                        endcase
                        if (q.lane == 2'd2) begin
                            d.lane = '0;
                            d.slot = q.slot + 1'b1;
                        end else begin
                            d.lane = q.lane + 1'b1;
                        end
                    end
                    d.sp = q.sp + 1'b1;
                    if (q.sp == SP_LAST) d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                if (take) begin
                    acc_en = 1'b1;
                    buf_we = q.dec;
                    d.pos  = q.pos + 1'b1;
                    if (q.pos == POS_LAST) d.st = ST_CHECK;
                end
            end
            ST_CHECK: begin
                acc_clr = 1'b1;
                if (q.dec) begin
                    buf_flip = (syn_res == CHK_FIXED);
                    if (syn_res == CHK_FAIL) d.fail = 1'b1;
                    d.st = ST_DRAIN;
                end else begin
                    d.code[q.chunk] = acc_code;
                    if (q.chunk == CHUNK_LAST) begin
                        d.st   = ST_SPARE_OUT;
                        d.sp   = '0;
                        d.slot = '0;
                        d.lane = '0;
                    end else begin
                        d.chunk = q.chunk + 1'b1;
                        d.st    = ST_DATA;
                    end
                end
            end
            ST_DRAIN: begin
                d.pos = q.pos + 1'b1;
                if (q.pos == POS_LAST) begin
                    if (q.chunk == CHUNK_LAST) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.chunk = q.chunk + 1'b1;
                        d.st    = ST_DATA;
                    end
                end
            end
            ST_SPARE_OUT: begin
                if (q.sp >= SP_BASE) begin
                    if (q.lane == 2'd2) begin
                        d.lane = '0;
                        d.slot = q.slot + 1'b1;
                    end else begin
                        d.lane = q.lane + 1'b1;
                    end
                end
                d.sp = q.sp + 1'b1;
                if (q.sp == SP_LAST) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        sp_byte = 8'hFF;
        if (q.sp >= SP_BASE) begin
            unique case (q.lane)
                2'd0:    sp_byte = q.code[q.slot][15:8];
                2'd1:    sp_byte = q.code[q.slot][7:0];
                default: sp_byte = q.code[q.slot][23:16];
            endcase
        end
    end

    assign dout_valid  = (q.st == ST_DRAIN);
    assign dout_data   = buf_rdata;
    assign dout_chunk  = q.chunk;
    assign dout_pos    = q.pos;
    assign chk_valid   = (q.st == ST_CHECK) && q.dec;
    assign chk_result  = syn_res;
    assign chk_chunk   = q.chunk;
    assign spare_valid = (q.st == ST_SPARE_OUT);
    assign spare_data  = sp_byte;
    assign spare_idx   = q.sp;
    assign page_done   = q.done;
    assign page_fail   = q.fail;

endmodule

// File: rtl/pg_ecc_engine_chk.sv
module pg_ecc_engine_chk #(
    parameter int PAGE_BYTES  = 2048,
    parameter int CHUNK_BYTES = 256,
    parameter int SPARE_BYTES = 64
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      in_ready,
    input logic                                      dout_valid,
    input logic [$clog2(CHUNK_BYTES)-1:0]            dout_pos,
    input logic                                      chk_valid,
    input logic [1:0]                                chk_result,
    input logic                                      spare_valid,
    input logic [7:0]                                spare_data,
    input logic [$clog2(SPARE_BYTES)-1:0]            spare_idx,
    input logic                                      page_done,
    input logic                                      page_fail
);
    localparam int IDX_W    = $clog2(CHUNK_BYTES);
    localparam int SPARE_W  = $clog2(SPARE_BYTES);
    localparam int ECC_BASE = SPARE_BYTES - 3 * (PAGE_BYTES / CHUNK_BYTES);
    localparam logic [IDX_W-1:0]   POS_LAST = IDX_W'(CHUNK_BYTES - 1);
    localparam logic [SPARE_W-1:0] SP_LAST  = SPARE_W'(SPARE_BYTES - 1);
    localparam logic [SPARE_W-1:0] SP_BASE  = SPARE_W'(ECC_BASE);

    p_spare_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spare_valid && spare_idx < SP_BASE) |-> spare_data == 8'hFF);

    p_spare_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spare_valid && spare_idx != SP_LAST) |=> (spare_valid && spare_idx == $past(spare_idx) + 1'b1));

    p_check_then_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> (dout_valid && dout_pos == '0));

    p_drain_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && dout_pos != POS_LAST) |=> (dout_valid && dout_pos == $past(dout_pos) + 1'b1));

    p_fail_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_result == 2'd3) |=> page_fail);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> !page_done);

    p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid || chk_valid || spare_valid || page_done) |-> !in_ready);

endmodule

bind pg_ecc_engine pg_ecc_engine_chk #(
    .PAGE_BYTES  (PAGE_BYTES),
    .CHUNK_BYTES (CHUNK_BYTES),
    .SPARE_BYTES (SPARE_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .dout_valid  (dout_valid),
    .dout_pos    (dout_pos),
    .chk_valid   (chk_valid),
    .chk_result  (chk_result),
    .spare_valid (spare_valid),
    .spare_data  (spare_data),
    .spare_idx   (spare_idx),
    .page_done   (page_done),
    .page_fail   (page_fail)
);

// File: tb/pg_ecc_engine_tb.sv
module pg_ecc_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE  = 2048;
    localparam int CHK   = 256;
    localparam int SPARE = 64;
    localparam int NCH   = PAGE / CHK;
    localparam int BASE  = SPARE - 3 * NCH;
    localparam int WD_LIMIT = 190000;

    typedef struct packed {
        logic       dec;
        logic [1:0] kind;   // 0 clean, 1 data bit, 2 code bit, 3 two data bits
        logic [7:0] seed;
        logic [2:0] chunk;
        logic [7:0] pos;
        logic [4:0] bitn;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 2'd0, 8'd1,  3'd0, 8'd0,   5'd0},
        '{1'b0, 2'd0, 8'd2,  3'd0, 8'd0,   5'd0},
        '{1'b1, 2'd0, 8'd3,  3'd0, 8'd0,   5'd0},
        '{1'b1, 2'd1, 8'd4,  3'd0, 8'd0,   5'd0},
        '{1'b1, 2'd1, 8'd5,  3'd7, 8'd255, 5'd7},
        '{1'b1, 2'd1, 8'd6,  3'd3, 8'h5a,  5'd4},
        '{1'b1, 2'd2, 8'd7,  3'd2, 8'd0,   5'd5},
        '{1'b1, 2'd2, 8'd8,  3'd6, 8'd0,   5'd23},
        '{1'b1, 2'd3, 8'd9,  3'd4, 8'h10,  5'd2},
        '{1'b1, 2'd0, 8'd10, 3'd0, 8'd0,   5'd0},
        '{1'b1, 2'd2, 8'd11, 3'd0, 8'd0,   5'd16}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic page_start = 1'b0;
    logic start_decode = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, dout_valid, chk_valid, spare_valid, page_done, page_fail;
    logic [7:0] dout_data, spare_data;
    logic [2:0] dout_chunk, chk_chunk;
    logic [7:0] dout_pos;
    logic [1:0] chk_result;
    logic [5:0] spare_idx;

    pg_ecc_engine u_dut (
        .clk(clk), .rst_n(rst_n), .page_start(page_start), .start_decode(start_decode),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .dout_valid(dout_valid), .dout_data(dout_data), .dout_chunk(dout_chunk),
        .dout_pos(dout_pos), .chk_valid(chk_valid), .chk_result(chk_result),
        .chk_chunk(chk_chunk), .spare_valid(spare_valid), .spare_data(spare_data),
        .spare_idx(spare_idx), .page_done(page_done), .page_fail(page_fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0]  clean [PAGE];
    logic [7:0]  txd   [PAGE];
    logic [7:0]  spr   [SPARE];
    logic [7:0]  strm  [PAGE + SPARE];
    logic [7:0]  got   [PAGE];
    logic [7:0]  gsp   [SPARE];
    logic [1:0]  gres  [NCH];
    logic [23:0] codes [NCH];
    int n_strm, n_out, n_res;
    bit done_seen, fail_at_done, ready_clash;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT && !finished) begin
            n_bad = n_bad + 1;
            $display("FAIL R9 watchdog expired: actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_code(input int base);
        logic [15:0] ln = '0;
        logic [7:0]  cx = '0;
        logic [5:0]  cp = '0;
        for (int i = 0; i < CHK; i++) begin
            logic p;
            p = ^clean[base + i];
            cx = cx ^ clean[base + i];
            for (int j = 0; j < 8; j++) begin
                if (i[j]) ln[2*j+1] = ln[2*j+1] ^ p;
                else      ln[2*j]   = ln[2*j]   ^ p;
            end
        end
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < 8; n++)
                if (n[k]) cp[2*k+1] = cp[2*k+1] ^ cx[n];
                else      cp[2*k]   = cp[2*k]   ^ cx[n];
        return {2'b11, cp, ln};
    endfunction

    task automatic build(input logic [7:0] seed);
        for (int i = 0; i < PAGE; i++) begin
            clean[i] = 8'(i * 7 + int'(seed) * 13 + (i >> 5));
            txd[i] = clean[i];
        end
        for (int c = 0; c < NCH; c++) codes[c] = ref_code(c * CHK);
    endtask

    task automatic feed();
        int idx = 0;
        while (idx < n_strm) begin
            @(negedge clk);
            if (in_ready) begin
                in_valid = 1'b1;
                in_data  = strm[idx];
                idx++;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic monitor();
        int guard = 0;
        n_out = 0; n_res = 0; done_seen = 0; ready_clash = 0; fail_at_done = 0;
        while (!done_seen && guard < 12000) begin
            @(negedge clk);
            guard++;
            if (chk_valid) begin gres[chk_chunk] = chk_result; n_res++; end
            if (dout_valid) begin got[int'(dout_chunk) * CHK + int'(dout_pos)] = dout_data; n_out++; end
            if (spare_valid) gsp[spare_idx] = spare_data;
            if ((dout_valid || chk_valid || spare_valid) && in_ready) ready_clash = 1;
            if (page_done) begin done_seen = 1; fail_at_done = page_fail; end
        end
    endtask

    task automatic start_page(input logic dec);
        @(negedge clk);
        page_start = 1'b1;
        start_decode = dec;
        @(negedge clk);
        page_start = 1'b0;
        start_decode = 1'b0;
    endtask

    task automatic glitch_start();
        repeat (300) @(negedge clk);
        page_start = 1'b1;
        start_decode = 1'b1;
        @(negedge clk);
        page_start = 1'b0;
        start_decode = 1'b0;
    endtask

    task automatic run_encode(input logic [7:0] seed, input bit glitch);
        int pad_bad = 0;
        build(seed);
        for (int i = 0; i < PAGE; i++) strm[i] = clean[i];
        n_strm = PAGE;
        start_page(1'b0);
        if (glitch) fork feed(); monitor(); glitch_start(); join
        else        fork feed(); monitor(); join
        check(done_seen, "R9 encode page_done", done_seen, 1);
        check(!ready_clash, "R10 in_ready while emitting", ready_clash, 0);
        for (int i = 0; i < BASE; i++) if (gsp[i] !== 8'hFF) pad_bad++;
        check(pad_bad == 0, "R2 pad bytes 0xFF", pad_bad, 0);
        for (int c = 0; c < NCH; c++) begin
            logic [23:0] v;
            v = {gsp[BASE + 3*c + 2], gsp[BASE + 3*c], gsp[BASE + 3*c + 1]};
            check(v === codes[c], glitch ? "R9 ignored page_start code" : "R1 R3 chunk code", v, codes[c]);
        end
    endtask

    task automatic run_decode(input vec_t v);
        int base;
        int mism = 0;
        logic [23:0] sc [NCH];
        logic [1:0]  eres;
        string tg;
        build(v.seed);
        base = int'(v.chunk) * CHK + int'(v.pos);
        for (int c = 0; c < NCH; c++) sc[c] = codes[c];
        case (v.kind)
            2'd1: txd[base][v.bitn[2:0]] = ~txd[base][v.bitn[2:0]];
            2'd2: sc[v.chunk][v.bitn] = ~sc[v.chunk][v.bitn];
            2'd3: begin
                txd[base][v.bitn[2:0]]     = ~txd[base][v.bitn[2:0]];
                txd[base ^ 1][v.bitn[2:0]] = ~txd[base ^ 1][v.bitn[2:0]];
            end
            default: ;
        endcase
        for (int i = 0; i < SPARE; i++) spr[i] = 8'hFF;
        for (int c = 0; c < NCH; c++) begin
            spr[BASE + 3*c]     = sc[c][15:8];
            spr[BASE + 3*c + 1] = sc[c][7:0];
            spr[BASE + 3*c + 2] = sc[c][23:16];
        end
        for (int i = 0; i < SPARE; i++) strm[i] = spr[i];
        for (int i = 0; i < PAGE; i++) strm[SPARE + i] = txd[i];
        n_strm = SPARE + PAGE;
        start_page(1'b1);
        fork feed(); monitor(); join
        tg = (v.kind == 2'd0) ? "R5" : (v.kind == 2'd1) ? "R6" : (v.kind == 2'd2) ? "R7" : "R8";
        check(done_seen, "R9 decode page_done", done_seen, 1);
        check(n_out == PAGE && n_res == NCH, "R4 released bytes and checks", n_out * 16 + n_res, PAGE * 16 + NCH);
        check(!ready_clash, "R10 in_ready while releasing", ready_clash, 0);
        for (int c = 0; c < NCH; c++) begin
            eres = (c == int'(v.chunk)) ? v.kind : 2'd0;
            check(gres[c] === eres, {tg, " chunk outcome"}, gres[c], eres);
        end
        for (int i = 0; i < PAGE; i++) begin
            logic [7:0] e;
            e = (v.kind == 2'd3) ? txd[i] : clean[i];
            if (got[i] !== e) begin
                if (mism == 0) check(0, {tg, " released data"}, got[i], e);
                mism++;
            end
        end
        if (mism == 0) check(1, {tg, " released data"}, 0, 0);
        check(fail_at_done == (v.kind == 2'd3), "R8 page_fail at done", fail_at_done, v.kind == 2'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(in_ready == 1'b0 && dout_valid == 1'b0 && chk_valid == 1'b0 && spare_valid == 1'b0,
              "R10 reset valids and ready", {in_ready, dout_valid, chk_valid, spare_valid}, 0);
        check(page_fail == 1'b0 && page_done == 1'b0, "R10 reset flags", {page_fail, page_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(in_ready == 1'b0, "R10 idle ready low", in_ready, 0);
        for (int n = 0; n < NVEC; n++) begin
            if (VEC[n].dec) run_decode(VEC[n]);
            else            run_encode(VEC[n].seed, 1'b0);
        end
        // R9: page_start during an encode page must be ignored
        run_encode(8'd42, 1'b1);
        repeat (2) @(negedge clk);
        check(in_ready == 1'b0 && page_done == 1'b0, "R9 idle after page", {in_ready, page_done}, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule